// File: doc/BRIEF.md
# Programmable Memory Region Decoder with Access Protection

The block compares every bus address against one programmable memory region. The region is described by a 22-bit base, a 4-bit size code on a doubling scale from 1KB to 16MB, a map-enable bit and two protection bits. When the access strobe is high and the address falls inside an enabled region, the memory select rises in the same cycle. The select stays low in two cases: the region is read-only and the access is a write, or the region is restricted to privileged code and the access is a user access. In either case a single-cycle illegal-access exception is raised in the following cycle.

Software reaches the configuration through two 16-bit register halves. The lower half holds base bits 15:10 in bits 15:10, the map-enable bit in bit 8, the size code in bits 7:4, the read-only bit in bit 1 and the privileged-only bit in bit 0. Bits 9, 3 and 2 are reserved. The upper half holds base bits 31:16. Writes take effect on the clock edge. Reads are combinational.

A small state machine shapes the exception output. It has three states:
- `ST_IDLE`: no pending fault.
- `ST_FAULT`: the exception is asserted.
- `ST_HOLD`: the violating access is still present, and the machine waits for it to end.

It has five transitions:
- `IDLE→FAULT` when a violation is seen.
- `FAULT→HOLD` when the violation persists.
- `FAULT→IDLE` when the violation has ended.
- `HOLD→IDLE` when the violation ends.
- `HOLD→HOLD` while the violation persists.

Top module: `mem_region_decoder`

## Requirements
- R1: After reset both register halves read 0. The region is disabled, and neither the select nor the exception is asserted for any access.
- R2: Writing with `cfg_sel`=0 updates the lower half, and writing with `cfg_sel`=1 updates the upper half (base bits 31:16). Both halves read back what was written. The exception is the lower half's bits 9, 3 and 2, which always read 0 and ignore writes.
- R3: While the map-enable bit (lower bit 8) is 0, the select is never asserted, whatever the other fields hold.
- R4: Size code 0 (lower bits 7:4) disables the select.
- R5: Size code n from 1 to 15 makes the region 2^(n+9) bytes. An address hits when its bits 31 down to n+9 equal the same base bits. Base bits below n+9 are ignored.
- R6: On a hit with no violation, the select is high in the same cycle as the access strobe. It is low whenever the strobe is low.
- R7: With the read-only bit (lower bit 1) set, a write that hits the region keeps the select low and raises the exception. A read that hits the region is selected normally.
- R8: With the privileged-only bit (lower bit 0) set, a hit made with the privilege flag low keeps the select low and raises the exception. A hit made with the flag high is selected normally.
- R9: The exception is high for exactly one cycle, the cycle after the violating access is first presented. A violation that breaks both rules, or that is held for several cycles, gives one pulse.
- R10: An access that misses the region never raises the exception, whatever its protection bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register half select: 0 lower, 1 upper |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for the selected half |
| acc_addr | input | 32 | Bus address |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_priv | input | 1 | 1 when the access is made in privilege mode |
| mem_sel | output | 1 | Memory select for the region |
| illegal_exc | output | 1 | Illegal-access exception pulse |

## Verification
The hardest situation to reach from the ports is a violation that lasts longer than one cycle, because the exception must not repeat. The bench holds a violating access for several cycles and counts the exception cycles. It does the same for an access that breaks both protection rules at once.

The size-masking boundary is approached from both sides. Addresses are placed just inside and just outside the region at the smallest, a middle and the largest size code. Base bits below the compare boundary are deliberately non-zero, to show that they are ignored.

// File: rtl/mem_region_pkg.sv
package mem_region_pkg;
    localparam int ADDR_W   = 32;
    localparam int GRAN_LSB = 10;
    localparam int REG_W    = 16;
    localparam int SIZE_W   = 4;
    localparam int BASE_W   = ADDR_W - GRAN_LSB;
    localparam int LO_BASE_W = REG_W - GRAN_LSB;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              map_en;
        logic [SIZE_W-1:0] size_code;
        logic              rd_only;
        logic              priv_only;
    } region_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FAULT = 2'd1,
        ST_HOLD  = 2'd2
    } exc_state_t;
endpackage

// File: rtl/region_regs.sv
module region_regs
    import mem_region_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output region_cfg_t      cfg
);
    localparam int HI_W = BASE_W - LO_BASE_W;

    logic unused_rsvd;
    assign unused_rsvd = ^{cfg_wdata[9], cfg_wdata[3:2]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel) begin
                cfg.base[BASE_W-1:LO_BASE_W] <= cfg_wdata[HI_W-1:0];
            end else begin
                cfg.base[LO_BASE_W-1:0] <= cfg_wdata[REG_W-1:GRAN_LSB];
                cfg.map_en              <= cfg_wdata[8];
                cfg.size_code           <= cfg_wdata[7:4];
                cfg.rd_only             <= cfg_wdata[1];
                cfg.priv_only           <= cfg_wdata[0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_sel) begin
            cfg_rdata[HI_W-1:0] = cfg.base[BASE_W-1:LO_BASE_W];
        end else begin
            cfg_rdata[REG_W-1:GRAN_LSB] = cfg.base[LO_BASE_W-1:0];
            cfg_rdata[8]                = cfg.map_en;
            cfg_rdata[7:4]              = cfg.size_code;
            cfg_rdata[1]                = cfg.rd_only;
            cfg_rdata[0]                = cfg.priv_only;
        end
    end

    AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel) |=> (cfg.base[BASE_W-1:LO_BASE_W] == $past(cfg_wdata[HI_W-1:0]))); // R2
    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel) |=> $stable(cfg.base[BASE_W-1:LO_BASE_W])); // R2
endmodule

// File: rtl/region_match.sv
module region_match
    import mem_region_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] cmp_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] diff;

    assign base_full = {cfg.base, {GRAN_LSB{1'b0}}};

    generate
        for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
            if (i < GRAN_LSB) begin : g_below
                assign cmp_mask[i] = 1'b0;
            end else begin : g_cmp
                assign cmp_mask[i] = (int'(cfg.size_code) + GRAN_LSB - 1) <= i;
            end
        end
    endgenerate

    assign diff = (addr ^ base_full) & cmp_mask;
    assign hit  = cfg.map_en && (cfg.size_code != '0) && (diff == '0);

    always_comb begin
        if (hit) begin
            AST_HIT_TOP_BIT_MATCH: assert (addr[ADDR_W-1] == base_full[ADDR_W-1]); // R5
        end
    end
endmodule

// File: rtl/prot_check.sv
module prot_check
    import mem_region_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  region_cfg_t cfg,
    input  logic        hit,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_priv,
    output logic        mem_sel,
    output logic        illegal_exc
);
    exc_state_t state, state_nxt;
    logic       viol;

    assign viol = acc_valid && hit &&
                  ((cfg.rd_only && acc_write) || (cfg.priv_only && !acc_priv));
    assign mem_sel = acc_valid && hit && !viol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (viol) state_nxt = ST_FAULT;
            ST_FAULT: state_nxt = viol ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (!viol) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        illegal_exc = 1'b0;
        unique case (state)
            ST_FAULT: illegal_exc = 1'b1;
            default:  illegal_exc = 1'b0;
        endcase
    end

    AST_EXC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_exc |=> !illegal_exc); // R9
    AST_EXC_FOLLOWS_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_exc |-> $past(viol)); // R9
    AST_NO_SEL_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> !mem_sel); // R7
    AST_MISS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !hit) |=> (state == ST_IDLE)); // R10
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
    import mem_region_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_priv,
    output logic        mem_sel,
    output logic        illegal_exc
);
    region_cfg_t cfg;
    logic        hit;

    region_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    region_match u_match (
        .cfg  (cfg),
        .addr (acc_addr),
        .hit  (hit)
    );

    prot_check u_prot (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .hit         (hit),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_priv    (acc_priv),
        .mem_sel     (mem_sel),
        .illegal_exc (illegal_exc)
    );

    AST_SEL_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> cfg.map_en); // R3
    AST_SEL_NEEDS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (cfg.size_code != '0)); // R4
    AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> acc_valid); // R6
    AST_EXCL_OUTPUTS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && cfg.rd_only) |-> !mem_sel); // R7
    AST_EXCL_OUTPUTS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv && cfg.priv_only) |-> !mem_sel); // R8
endmodule

// File: tb/tb_mem_region_decoder.sv
`timescale 1ns/1ps
module tb_mem_region_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [31:0] acc_addr = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic        mem_sel;
    logic        illegal_exc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    mem_region_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_addr(acc_addr), .acc_valid(acc_valid), .acc_write(acc_write), .acc_priv(acc_priv),
        .mem_sel(mem_sel), .illegal_exc(illegal_exc)
    );

    // vector: lo[67:52] hi[51:36] addr[35:4] write[3] priv[2] exp_sel[1] exp_exc[0]
    localparam int NV = 15;
    localparam logic [67:0] VEC [NV] = '{
        {16'h0510, 16'h1234, 32'h1234_0400, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 R6 1KB base
        {16'h0510, 16'h1234, 32'h1234_0800, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 1KB just above
        {16'h0510, 16'h1234, 32'h1234_07FC, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 1KB top word
        {16'h0530, 16'h1234, 32'h1234_0C00, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 4KB low base bits ignored
        {16'h0530, 16'h1234, 32'h1234_1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 4KB just above
        {16'h05F0, 16'h1234, 32'h12FF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 16MB top
        {16'h05F0, 16'h1234, 32'h1300_0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 16MB just above
        {16'h0512, 16'h1234, 32'h1234_0400, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 write to read-only
        {16'h0512, 16'h1234, 32'h1234_0400, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 read of read-only
        {16'h0511, 16'h1234, 32'h1234_0400, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 user into priv region
        {16'h0511, 16'h1234, 32'h1234_0400, 1'b1, 1'b1, 1'b1, 1'b0}, // R8 priv access allowed
        {16'h0513, 16'h1234, 32'h1234_0400, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 both rules broken
        {16'h0410, 16'h1234, 32'h1234_0400, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 map disabled
        {16'h0500, 16'h1234, 32'h1234_0400, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 size code zero
        {16'h0513, 16'h1234, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0}  // R10 miss with protection
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [15:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic w, input logic p,
                          input logic es, input logic ee);
        @(negedge clk);
        acc_addr = a; acc_write = w; acc_priv = p; acc_valid = 1'b1;
        #1 check({tag, " sel"}, {31'b0, mem_sel}, {31'b0, es});
        @(negedge clk);
        acc_valid = 1'b0;
        #1 check({tag, " exc"}, {31'b0, illegal_exc}, {31'b0, ee});
        @(negedge clk);
        #1 check({tag, " exc end"}, {31'b0, illegal_exc}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(1'b0, rd); check("R1 lo reset", {16'b0, rd}, 32'd0);
        reg_read(1'b1, rd); check("R1 hi reset", {16'b0, rd}, 32'd0);
        access("R1 access after reset", 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0);

        // R2 register layout and reserved bits
        reg_write(1'b0, 16'hFFFF);
        reg_read(1'b0, rd); check("R2 lo reserved zero", {16'b0, rd}, 32'h0000_FDF3);
        reg_write(1'b1, 16'hABCD);
        reg_read(1'b1, rd); check("R2 hi readback", {16'b0, rd}, 32'h0000_ABCD);
        reg_read(1'b0, rd); check("R2 lo untouched by hi", {16'b0, rd}, 32'h0000_FDF3);

        // table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(1'b0, VEC[i][67:52]);
            reg_write(1'b1, VEC[i][51:36]);
            access($sformatf("vec%0d", i), VEC[i][35:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R6 strobe low gives no select on a hitting address
        reg_write(1'b0, 16'h0510); reg_write(1'b1, 16'h1234);
        @(negedge clk);
        acc_addr = 32'h1234_0400; acc_valid = 1'b0;
        #1 check("R6 no strobe no sel", {31'b0, mem_sel}, 32'd0);

        // R9 held violation gives one pulse
        reg_write(1'b0, 16'h0513);
        @(negedge clk);
        acc_addr = 32'h1234_0400; acc_write = 1'b1; acc_priv = 1'b0; acc_valid = 1'b1;
        pulses = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            #1 if (illegal_exc) pulses++;
        end
        acc_valid = 1'b0;
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            #1 if (illegal_exc) pulses++;
        end
        check("R9 held violation single pulse", pulses, 32'd1);

        // R9 back-to-back distinct violations each pulse
        access("R9 second violation", 32'h1234_0400, 1'b0, 1'b0, 1'b0, 1'b1);

        finish_run();
    end
endmodule